// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Macrocell Array

This block models a small field-configurable logic core. A programmable AND plane forms product terms from eight dedicated inputs and eight feedback signals, each available in true and complemented form. A fixed OR gathers eight terms for each of eight output cells. Each cell applies a polarity bit and then acts as a registered output, a combinatorial output, a combinatorial I/O whose enable comes from one product term, or a pure input. Pads appear as separate in, out and enable signals.

The configuration is held in rows that are written one at a time and read back combinationally. A sticky lock bit blanks readback until a full erase. The output registers can be preloaded directly so that any state can be forced. The asynchronous reset clears every register, which makes every registered output read high whatever its polarity.

Top module: `sop_logic_array`

## Requirements
- R1: While rst_ni is low, and right after it is released, every register is zero and every registered cell drives pad_o high, whatever its polarity bit.
- R2: Config row r (r < 64) is term r%8 of cell r/8. Array signal k is in_i[k] for k < 8 and the feedback of cell k-8 for k >= 8. Row bit 2k selects signal k true and bit 2k+1 selects it complemented. A term is the AND of its selected literals, and a term with no bit set is 0.
- R3: The cell sum is the OR of its eight terms, or of terms 1..7 when term 0 serves as the enable. The pad level equals the sum when the cell's polarity bit is 1 and its inverse when the bit is 0.
- R4: Config row 64 is the control row: bits [7:0] input select per cell, [15:8] polarity per cell, bit 16 global A, bit 17 global B, bit 18 lock. With B=1 the array is in complex mode, with A=1 and B=0 in simple mode, and with both 0 in registered mode.
- R5: In registered mode a cell whose select bit is 0 is registered. Its pad shows the level of R3 captured at the last rising edge, and its enable is ~oe_ni.
- R6: Cells in complex mode, and cells in registered mode whose select bit is 1, are combinatorial I/O: the enable is term 0, the output is the R3 level, and the feedback is pad_i.
- R7: In simple mode, a cell whose select bit is 0 is an always-enabled combinatorial output, and a cell whose select bit is 1 is a disabled input. Feedback is pad_i except as stated in R8.
- R8: In simple mode the two centre cells (3 and 4) feed 0 into the array while they are combinatorial outputs.
- R9: The feedback of a registered cell is its registered pad level.
- R10: With pre_en_i high at an edge, every register loads so that the registered pads show pre_data_i. This takes priority over normal capture.
- R11: cfg_rdata_o returns the row at cfg_raddr_i (the control row at 64, 0 beyond it). Once a control write sets the lock bit, every read returns 0, and later writes cannot clear the lock.
- R12: A cfg_erase_i pulse clears all rows and the lock at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low register clear |
| in_i | input | N_IN | Dedicated array inputs |
| oe_ni | input | 1 | Global enable for registered pads, active low |
| pad_i | input | N_CELL | Pad input values |
| pad_o | output | N_CELL | Pad output values |
| pad_oe_o | output | N_CELL | Pad output enables |
| cfg_we_i | input | 1 | Config row write strobe |
| cfg_erase_i | input | 1 | Clear all config and the lock |
| cfg_addr_i | input | AW | Config write row |
| cfg_wdata_i | input | ROW_W | Config write data |
| cfg_raddr_i | input | AW | Config read row |
| cfg_rdata_o | output | ROW_W | Config read data |
| pre_en_i | input | 1 | Register preload strobe |
| pre_data_i | input | N_CELL | Pad levels to force into the registers |

## Verification
The preload property assumes that no control write lands in the edge that carries pre_en_i, so the set of registered cells is the same one cycle later. The stimulus holds pre_en_i low in every write cycle. The lock properties assume the configuration has been erased at least once under reset, because the config rows have no reset of their own; the stimulus erases while rst_ni is low. Random sparse fuse patterns are swept in all four global mode codes, with random select and polarity bits, and checked against a model built from the requirements.

// File: rtl/sop_pkg.sv
package sop_pkg;
  typedef enum logic [1:0] {
    MODE_REG    = 2'b00,
    MODE_SIMPLE = 2'b01,
    MODE_CPLX   = 2'b10,
    MODE_CPLX_A = 2'b11
  } mode_e;

  function automatic bit is_centre(int idx, int n);
    return (idx == n / 2 - 1) || (idx == n / 2);
  endfunction
endpackage

// File: rtl/sop_cfg_store.sv
module sop_cfg_store
  import sop_pkg::*;
#(
  parameter int N_CELL = 8,
  parameter int N_ROW  = 64,
  parameter int ROW_W  = 32,
  localparam int AW    = $clog2(N_ROW + 1),
  localparam int RW    = $clog2(N_ROW)
) (
  input  logic                        clk_i,
  input  logic                        erase_i,
  input  logic                        we_i,
  input  logic [AW-1:0]               addr_i,
  input  logic [ROW_W-1:0]            wdata_i,
  input  logic [AW-1:0]               raddr_i,
  output logic [N_ROW-1:0][ROW_W-1:0] fuse_o,
  output mode_e                       mode_o,
  output logic [N_CELL-1:0]           sl0_o,
  output logic [N_CELL-1:0]           sl1_o,
  output logic                        lock_o,
  output logic [ROW_W-1:0]            rdata_o
);
  localparam int SL1_LSB  = N_CELL;
  localparam int SGA_BIT  = 2 * N_CELL;
  localparam int SGB_BIT  = 2 * N_CELL + 1;
  localparam int LOCK_BIT = 2 * N_CELL + 2;

  logic [N_ROW-1:0][ROW_W-1:0] fuse_q;
  logic [ROW_W-1:0]            ctl_q;
  logic                        lock_q;

  // non-volatile image: cleared only by erase
  always_ff @(posedge clk_i) begin
    if (erase_i) begin
      fuse_q <= '0;
      ctl_q  <= '0;
      lock_q <= 1'b0;
    end else if (we_i) begin
      if (addr_i < AW'(N_ROW)) begin
        fuse_q[addr_i[RW-1:0]] <= wdata_i;
      end else if (addr_i == AW'(N_ROW)) begin
        ctl_q  <= wdata_i;
        lock_q <= lock_q | wdata_i[LOCK_BIT];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (!lock_q) begin
      if (raddr_i < AW'(N_ROW)) rdata_o = fuse_q[raddr_i[RW-1:0]];
      else if (raddr_i == AW'(N_ROW)) rdata_o = ctl_q;
    end
  end

  assign fuse_o = fuse_q;
  assign mode_o = mode_e'({ctl_q[SGB_BIT], ctl_q[SGA_BIT]});
  assign sl0_o  = ctl_q[N_CELL-1:0];
  assign sl1_o  = ctl_q[SL1_LSB +: N_CELL];
  assign lock_o = lock_q;
endmodule

// File: rtl/sop_and_array.sv
module sop_and_array #(
  parameter int N_SIG  = 16,
  parameter int N_TERM = 64,
  localparam int COL_W = 2 * N_SIG
) (
  input  logic [N_SIG-1:0]              sig_i,
  input  logic [N_TERM-1:0][COL_W-1:0]  fuse_i,
  output logic [N_TERM-1:0]             pt_o
);
  logic [COL_W-1:0] lit;

  for (genvar k = 0; k < N_SIG; k++) begin : g_lit
    assign lit[2*k]   = sig_i[k];
    assign lit[2*k+1] = ~sig_i[k];
  end

  // unconnected term evaluates to 0
  for (genvar r = 0; r < N_TERM; r++) begin : g_term
    assign pt_o[r] = (|fuse_i[r]) & (&(lit | ~fuse_i[r]));
  end
endmodule

// File: rtl/sop_macrocell.sv
module sop_macrocell
  import sop_pkg::*;
#(
  parameter int N_PT   = 8,
  parameter bit CENTRE = 1'b0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_PT-1:0] pt_i,
  input  mode_e           mode_i,
  input  logic            sl0_i,
  input  logic            sl1_i,
  input  logic            oe_ni,
  input  logic            pad_i,
  input  logic            pre_en_i,
  input  logic            pre_val_i,
  output logic            pad_o,
  output logic            pad_oe_o,
  output logic            fb_o
);
  logic is_reg, is_simple, oe_term, sum, lvl, q;

  always_comb begin
    is_simple = (mode_i == MODE_SIMPLE);
    is_reg    = (mode_i == MODE_REG) && !sl0_i;
    oe_term   = !is_simple && !is_reg;
    sum       = oe_term ? |pt_i[N_PT-1:1] : |pt_i;
    lvl       = ~(sum ^ sl1_i);
    pad_o     = is_reg ? ~q : lvl;
    if (is_reg)         pad_oe_o = ~oe_ni;
    else if (is_simple) pad_oe_o = ~sl0_i;
    else                pad_oe_o = pt_i[0];
    if (is_reg)                               fb_o = ~q;
    else if (CENTRE && is_simple && !sl0_i)   fb_o = 1'b0;
    else                                      fb_o = pad_i;
  end

  // register holds the inverted pad level so that clear reads high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q <= 1'b0;
    else if (pre_en_i) q <= ~pre_val_i;
    else               q <= ~lvl;
  end
endmodule

// File: rtl/sop_logic_array.sv
module sop_logic_array
  import sop_pkg::*;
#(
  parameter int N_IN   = 8,
  parameter int N_CELL = 8,
  parameter int N_PT   = 8,
  localparam int N_SIG = N_IN + N_CELL,
  localparam int ROW_W = 2 * N_SIG,
  localparam int N_ROW = N_CELL * N_PT,
  localparam int AW    = $clog2(N_ROW + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_IN-1:0]   in_i,
  input  logic              oe_ni,
  input  logic [N_CELL-1:0] pad_i,
  output logic [N_CELL-1:0] pad_o,
  output logic [N_CELL-1:0] pad_oe_o,
  input  logic              cfg_we_i,
  input  logic              cfg_erase_i,
  input  logic [AW-1:0]     cfg_addr_i,
  input  logic [ROW_W-1:0]  cfg_wdata_i,
  input  logic [AW-1:0]     cfg_raddr_i,
  output logic [ROW_W-1:0]  cfg_rdata_o,
  input  logic              pre_en_i,
  input  logic [N_CELL-1:0] pre_data_i
);
  logic [N_ROW-1:0][ROW_W-1:0] fuse;
  mode_e                       mode;
  logic [N_CELL-1:0]           sl0, sl1, fb;
  logic                        lock;
  logic [N_ROW-1:0]            pt;

  sop_cfg_store #(.N_CELL(N_CELL), .N_ROW(N_ROW), .ROW_W(ROW_W)) u_cfg (
    .clk_i   (clk_i),
    .erase_i (cfg_erase_i),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .raddr_i (cfg_raddr_i),
    .fuse_o  (fuse),
    .mode_o  (mode),
    .sl0_o   (sl0),
    .sl1_o   (sl1),
    .lock_o  (lock),
    .rdata_o (cfg_rdata_o)
  );

  sop_and_array #(.N_SIG(N_SIG), .N_TERM(N_ROW)) u_and (
    .sig_i  ({fb, in_i}),
    .fuse_i (fuse),
    .pt_o   (pt)
  );

  for (genvar c = 0; c < N_CELL; c++) begin : g_cell
    localparam bit CTR = is_centre(c, N_CELL);
    sop_macrocell #(.N_PT(N_PT), .CENTRE(CTR)) u_mc (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .pt_i      (pt[c*N_PT +: N_PT]),
      .mode_i    (mode),
      .sl0_i     (sl0[c]),
      .sl1_i     (sl1[c]),
      .oe_ni     (oe_ni),
      .pad_i     (pad_i[c]),
      .pre_en_i  (pre_en_i),
      .pre_val_i (pre_data_i[c]),
      .pad_o     (pad_o[c]),
      .pad_oe_o  (pad_oe_o[c]),
      .fb_o      (fb[c])
    );
  end
endmodule

// File: rtl/sop_logic_array_chk.sv
module sop_logic_array_chk
  import sop_pkg::*;
#(
  parameter int N_CELL = 8,
  parameter int ROW_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              oe_ni,
  input logic              pre_en_i,
  input logic [N_CELL-1:0] pre_data_i,
  input logic [N_CELL-1:0] pad_o,
  input logic [N_CELL-1:0] pad_oe_o,
  input logic              cfg_erase_i,
  input logic [ROW_W-1:0]  cfg_rdata_o,
  input mode_e             mode,
  input logic [N_CELL-1:0] sl0,
  input logic              lock
);
  logic [N_CELL-1:0] reg_mask;
  assign reg_mask = (mode == MODE_REG) ? ~sl0 : '0;

  a_r10_preload_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_en_i |=> (((pad_o ^ $past(pre_data_i)) & reg_mask) == '0));

  a_r5_reg_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((pad_oe_o ^ {N_CELL{~oe_ni}}) & reg_mask) == '0));

  a_r7_simple_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_SIMPLE) |-> (pad_oe_o == ~sl0));

  a_r11_locked_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock |-> (cfg_rdata_o == '0));

  a_r11_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock && !cfg_erase_i) |=> lock);

  a_r12_erase_unlocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_erase_i |=> !lock);
endmodule

bind sop_logic_array sop_logic_array_chk #(.N_CELL(N_CELL), .ROW_W(ROW_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .oe_ni       (oe_ni),
  .pre_en_i    (pre_en_i),
  .pre_data_i  (pre_data_i),
  .pad_o       (pad_o),
  .pad_oe_o    (pad_oe_o),
  .cfg_erase_i (cfg_erase_i),
  .cfg_rdata_o (cfg_rdata_o),
  .mode        (mode),
  .sl0         (sl0),
  .lock        (lock)
);

// File: tb/sim_sop_logic_array.sv
module sim_sop_logic_array;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  in_v, pad_iv, pad_o, pad_oe, pre_d;
  logic        oe_n, we, erase, pre_en;
  logic [6:0]  addr, raddr;
  logic [31:0] wdata, rdata;

  logic [31:0] fz [64];
  logic [31:0] m_ctl;
  logic        m_lock;
  logic [7:0]  qm;
  int n_vec = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  sop_logic_array u0 (
    .clk_i(clk), .rst_ni(rst_ni), .in_i(in_v), .oe_ni(oe_n), .pad_i(pad_iv),
    .pad_o(pad_o), .pad_oe_o(pad_oe), .cfg_we_i(we), .cfg_erase_i(erase),
    .cfg_addr_i(addr), .cfg_wdata_i(wdata), .cfg_raddr_i(raddr),
    .cfg_rdata_o(rdata), .pre_en_i(pre_en), .pre_data_i(pre_d)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model built from the requirements
  task automatic eval(output logic [7:0] eo, output logic [7:0] eoe, output logic [7:0] enq);
    logic [7:0] fb;
    logic [15:0] sig;
    logic [63:0] pt;
    logic simple, regm, isreg, ioc, s, lvl, ok;
    simple = m_ctl[16] && !m_ctl[17];
    regm   = !m_ctl[16] && !m_ctl[17];
    for (int c = 0; c < 8; c++) begin
      isreg = regm && !m_ctl[c];
      if (isreg) fb[c] = ~qm[c];
      else if (simple && !m_ctl[c] && (c == 3 || c == 4)) fb[c] = 1'b0;
      else fb[c] = pad_iv[c];
    end
    sig = {fb, in_v};
    for (int r = 0; r < 64; r++) begin
      ok = 1'b1;
      for (int k = 0; k < 16; k++) begin
        if (fz[r][2*k] && !sig[k]) ok = 1'b0;
        if (fz[r][2*k+1] && sig[k]) ok = 1'b0;
      end
      pt[r] = (fz[r] != 0) && ok;
    end
    for (int c = 0; c < 8; c++) begin
      isreg = regm && !m_ctl[c];
      ioc = !simple && !isreg;
      s = 1'b0;
      for (int t = (ioc ? 1 : 0); t < 8; t++) s = s | pt[c*8+t];
      lvl = m_ctl[8+c] ? s : !s;
      eo[c]  = isreg ? ~qm[c] : lvl;
      eoe[c] = isreg ? !oe_n : (simple ? !m_ctl[c] : pt[c*8]);
      enq[c] = pre_en ? !pre_d[c] : !lvl;
    end
  endtask

  task automatic tick(input string tag, input bit do_chk);
    logic [7:0] eo, eoe, enq;
    eval(eo, eoe, enq);
    #1;
    if (do_chk) chk(tag, {16'b0, pad_oe, pad_o & eoe}, {16'b0, eoe, eo & eoe});
    @(posedge clk);
    if (!rst_ni) qm = '0;
    else qm = enq;
    if (erase) begin
      for (int r = 0; r < 64; r++) fz[r] = '0;
      m_ctl = '0;
      m_lock = 1'b0;
    end else if (we) begin
      if (addr < 64) fz[addr[5:0]] = wdata;
      else if (addr == 64) begin
        m_ctl = wdata;
        m_lock = m_lock | wdata[18];
      end
    end
    @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d, input string tag, input bit do_chk);
    we = 1'b1; addr = 7'(a); wdata = d; pre_en = 1'b0;
    tick(tag, do_chk);
    we = 1'b0;
  endtask

  task automatic do_erase();
    erase = 1'b1;
    tick("", 1'b0);
    erase = 1'b0;
  endtask

  function automatic logic [31:0] rnd_row();
    logic [31:0] row;
    int k;
    row = '0;
    k = $urandom % 4;
    for (int j = 0; j < k; j++) row[$urandom % 32] = 1'b1;
    return row;
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    string tag;
    in_v = '0; pad_iv = '0; oe_n = 1'b0; we = 1'b0; erase = 1'b1;
    addr = '0; raddr = '0; wdata = '0; pre_en = 1'b0; pre_d = '0;
    qm = '0; m_ctl = '0; m_lock = 1'b0;
    for (int r = 0; r < 64; r++) fz[r] = '0;
    repeat (3) @(negedge clk);
    erase = 1'b0;
    rst_ni = 1'b1;
    #1;
    chk("R1 reset pads", {24'b0, pad_o}, 32'h0000_00FF);
    chk("R1 reset enables", {24'b0, pad_oe}, 32'h0000_00FF);
    @(negedge clk);
    repeat (3) tick("R1 R5 idle", 1'b1);

    // all polarity bits set, empty terms: registered pads fall to 0
    wr(64, 32'h0000_FF00, "R3", 1'b1);
    repeat (3) tick("R3 R5 polarity", 1'b1);
    chk("R3 empty sum high polarity", {24'b0, pad_o}, 32'h0);
    rst_ni = 1'b0;
    #1;
    chk("R1 async clear regardless of polarity", {24'b0, pad_o}, 32'h0000_00FF);
    @(negedge clk);
    rst_ni = 1'b1;
    qm = '0;

    // sweep all mode codes with random sparse arrays
    for (int m = 0; m < 4; m++) begin
      if (m == 0)      tag = "R2 R3 R5 R6 R9 R10 reg";
      else if (m == 1) tag = "R2 R3 R7 R8 simple";
      else             tag = "R2 R3 R4 R6 complex";
      for (int p = 0; p < 3; p++) begin
        for (int r = 0; r < 64; r++) wr(r, rnd_row(), tag, 1'b1);
        wr(64, {14'b0, 2'(m), 8'($urandom), 8'($urandom)}, tag, 1'b1);
        for (int i = 0; i < 150; i++) begin
          in_v   = 8'($urandom);
          pad_iv = 8'($urandom);
          oe_n   = (($urandom % 8) == 0);
          pre_en = (($urandom % 16) == 0);
          pre_d  = 8'($urandom);
          tick(tag, 1'b1);
        end
        pre_en = 1'b0;
        oe_n = 1'b0;
      end
    end

    // R8: centre cell 3 as combinatorial output feeds 0; cell 2 feeds pad_i
    do_erase();
    wr(0, 32'h0040_0000, "", 1'b0);
    wr(1, 32'h0010_0000, "", 1'b0);
    wr(64, 32'h0001_0100, "", 1'b0);
    pad_iv = 8'h08;
    #1 chk("R8 centre feedback blocked", {31'b0, pad_o[0]}, 32'h0);
    @(negedge clk);
    pad_iv = 8'h04;
    #1 chk("R7 outer feedback from pad", {31'b0, pad_o[0]}, 32'h1);
    chk("R7 outputs enabled", {24'b0, pad_oe}, 32'h0000_00FF);
    @(negedge clk);
    wr(64, 32'h0001_01F0, "", 1'b0);
    #1 chk("R7 input cells disabled", {24'b0, pad_oe}, 32'h0000_000F);
    @(negedge clk);

    // R10: preload beats capture, then capture resumes
    do_erase();
    pre_en = 1'b1; pre_d = 8'h5A;
    @(negedge clk);
    pre_en = 1'b0;
    #1 chk("R10 preload value", {24'b0, pad_o}, 32'h0000_005A);
    @(negedge clk);
    #1 chk("R5 capture after preload", {24'b0, pad_o}, 32'h0000_00FF);
    oe_n = 1'b1;
    #1 chk("R5 global enable off", {24'b0, pad_oe}, 32'h0);
    oe_n = 1'b0;
    @(negedge clk);

    // R11 / R12: readback, lock, erase
    wr(5, 32'hDEAD_BEEF, "", 1'b0);
    wr(64, 32'h0003_1234, "", 1'b0);
    raddr = 7'd5;
    #1 chk("R11 row readback", rdata, 32'hDEAD_BEEF);
    raddr = 7'd64;
    #1 chk("R11 control readback", rdata, 32'h0003_1234);
    raddr = 7'd70;
    #1 chk("R11 beyond rows", rdata, 32'h0);
    @(negedge clk);
    wr(64, 32'h0004_0000, "", 1'b0);
    raddr = 7'd5;
    #1 chk("R11 locked row blank", rdata, 32'h0);
    raddr = 7'd64;
    #1 chk("R11 locked control blank", rdata, 32'h0);
    @(negedge clk);
    wr(64, 32'h0000_0000, "", 1'b0);
    raddr = 7'd5;
    #1 chk("R11 lock sticky", rdata, 32'h0);
    @(negedge clk);
    do_erase();
    wr(7, 32'h1234_5678, "", 1'b0);
    raddr = 7'd7;
    #1 chk("R12 unlocked after erase", rdata, 32'h1234_5678);
    raddr = 7'd5;
    #1 chk("R12 old row cleared", rdata, 32'h0);
    @(negedge clk);

    summary();
    $finish;
  end
endmodule